// File: doc/BRIEF.md
# Guarded Byte-Store Register Controller

This block fronts a small byte-wide nonvolatile data store, modelled here as an internal 64-location array, and presents it to a CPU as three 8-bit I/O registers: a location pointer, a data byte and a command/status byte. Software places an address and a byte in the first two registers, then drives the store through the command register. A read is a single command: the addressed byte lands in the data register and the request bit clears itself. A write is a guarded two-step operation. Software first sets an arming bit, which lives only for a few clock cycles. It then sets the write bit before the arming bit lapses. The write then runs for a parameterised number of cycles with a busy bit raised, and hardware drops the busy bit at the end.

The block asks the CPU to stall for a fixed number of cycles after a read command and a shorter fixed number after a write starts. It raises a level interrupt whenever the store is idle, provided the local enable and the global interrupt enable are both set. A write to the pointer or data register while a write is running aborts that write. A defined poison byte (all ones) is then left in the target location.

Top module: `nvm_regblock`

## Requirements
- R1: After synchronous reset the command register reads 0x00, the data register reads 0x00, `irq` is 0 and `cpu_stall` is 0.
- R2: Register select `io_sel` encodes 0 = pointer, 1 = data, 2 = command, 3 = unused (reads 0x00). The pointer keeps 6 bits, and its bits 7:6 always read 0. The data register reads back the last byte written to it.
- R3: Command register fields are bit 3 = interrupt enable (read/write), bit 2 = arm, bit 1 = write/busy, bit 0 = read. Bits 7:4 always read 0. Writing 0 to bits 2..0 has no effect.
- R4: Setting bit 1 when the arm bit is not already set does not start a write. Busy stays 0 and the store is unchanged.
- R5: The arm bit reads 1 for exactly 4 cycles after the write that sets it, then clears itself. A write command issued in any of the 4 bus cycles after arming is accepted, and one issued in the 5th is rejected. Starting a write consumes the arm bit.
- R6: An accepted write holds busy for exactly WRITE_CYCLES cycles. It then stores the pointer and data values that were present when it started, and busy clears.
- R7: A read command loads the byte at the pointer into the data register. `cpu_stall` is high for exactly 4 cycles, the read bit reads 1 during that window and clears afterwards.
- R8: Starting a write raises `cpu_stall` for exactly 2 cycles.
- R9: `irq` equals interrupt-enable AND `gie` AND NOT busy.
- R10: Writing the pointer or data register while busy aborts the write at once, clears busy and leaves 0xFF in the location the aborted write targeted. The register takes the new value.
- R11: A read command issued while busy is ignored: no stall, and the data register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| io_sel | input | 2 | Register select: 0 pointer, 1 data, 2 command, 3 none |
| io_we | input | 1 | Register write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered readback of the selected register, valid the cycle after selection |
| gie | input | 1 | Global interrupt enable from the CPU |
| irq | output | 1 | Store-ready interrupt request (level) |
| cpu_stall | output | 1 | CPU stall request |

## Verification
The hardest situations to reach are the edges of the arming window and an abort in the middle of a write. Both depend on exactly how many bus cycles pass between two register writes, which ordinary driver code never controls. The bench places the write command 0 to 4 idle cycles after arming, and so lands on each side of the lapse. It also writes the pointer or data register partway through a running write, on purpose in directed cases and at random in the random phase. It then reads the targeted location back to confirm the poison byte, and reads another location to confirm the rest of the store is untouched.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [1:0] {
    SEL_PTR  = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CMD  = 2'd2,
    SEL_NONE = 2'd3
  } nvm_sel_e;

  localparam int CB_READ  = 0;
  localparam int CB_WRITE = 1;
  localparam int CB_ARM   = 2;
  localparam int CB_IRQEN = 3;
  localparam int REG_W    = 8;
endpackage

// File: rtl/nvm_array.sv
module nvm_array #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata_q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata_q <= mem[raddr];
  end
endmodule

// File: rtl/nvm_arm_timer.sv
module nvm_arm_timer #(
  parameter int ARM_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic consume_i,
  output logic armed_o
);
  localparam int CW = $clog2(ARM_CYCLES + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_o <= 1'b0;
      left_q  <= '0;
    end else if (consume_i) begin
      armed_o <= 1'b0;
      left_q  <= '0;
    end else if (set_i) begin
      armed_o <= 1'b1;
      left_q  <= CW'(ARM_CYCLES - 1);
    end else if (armed_o) begin
      if (left_q == '0) armed_o <= 1'b0;
      else              left_q  <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/nvm_write_seq.sv
module nvm_write_seq #(
  parameter int WRITE_CYCLES = 1024,
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          busy_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_data_o
);
  localparam int CW = $clog2(WRITE_CYCLES + 1);

  logic [CW-1:0] left_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          finish;

  assign finish     = busy_o && (left_q == '0);
  assign mem_we_o   = busy_o && (abort_i || finish);
  assign mem_addr_o = addr_q;
  assign mem_data_o = abort_i ? {DW{1'b1}} : data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      left_q <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (busy_o) begin
      if (abort_i || finish) busy_o <= 1'b0;
      else                   left_q <= left_q - 1'b1;
    end else if (start_i) begin
      busy_o <= 1'b1;
      left_q <= CW'(WRITE_CYCLES - 1);
      addr_q <= addr_i;
      data_q <= data_i;
    end
  end

  // R6: a running write never lasts past its count
  p_busy_ends_r6: assert property (@(posedge clk) disable iff (rst)
    (busy_o && left_q == '0) |=> !busy_o);
endmodule

// File: rtl/nvm_stall.sv
module nvm_stall #(
  parameter int RD_STALL = 4,
  parameter int WR_STALL = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic load_rd_i,
  input  logic load_wr_i,
  output logic stall_o,
  output logic rd_phase_o
);
  localparam int MAXS = (RD_STALL > WR_STALL) ? RD_STALL : WR_STALL;
  localparam int CW   = $clog2(MAXS + 1);

  logic [CW-1:0] left_q;
  logic          rd_kind_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q    <= '0;
      rd_kind_q <= 1'b0;
    end else if (load_rd_i) begin
      left_q    <= CW'(RD_STALL);
      rd_kind_q <= 1'b1;
    end else if (load_wr_i) begin
      left_q    <= CW'(WR_STALL);
      rd_kind_q <= 1'b0;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign stall_o    = (left_q != '0);
  assign rd_phase_o = rd_kind_q && stall_o;
endmodule

// File: rtl/nvm_regblock.sv
module nvm_regblock #(
  parameter int ADDR_BITS    = 6,
  parameter int WRITE_CYCLES = 1024,
  parameter int ARM_CYCLES   = 4,
  parameter int RD_STALL     = 4,
  parameter int WR_STALL     = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] io_sel,
  input  logic       io_we,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata,
  input  logic       gie,
  output logic       irq,
  output logic       cpu_stall
);
  import nvm_pkg::*;

  localparam int DW = REG_W;

  nvm_sel_e sel;
  assign sel = nvm_sel_e'(io_sel);

  logic                 wr_ptr, wr_data, wr_cmd;
  logic [ADDR_BITS-1:0] ptr_q;
  logic [DW-1:0]        data_q;
  logic                 irqen_q;
  logic                 rd_load_q;
  logic                 armed, busy, rd_phase;
  logic                 start_wr, start_rd, abort;
  logic                 mem_we;
  logic [ADDR_BITS-1:0] mem_waddr;
  logic [DW-1:0]        mem_wdata, mem_rdata;
  logic [DW-1:0]        cmd_view, ptr_view;

  assign wr_ptr  = io_we && (sel == SEL_PTR);
  assign wr_data = io_we && (sel == SEL_DATA);
  assign wr_cmd  = io_we && (sel == SEL_CMD);

  assign start_wr = wr_cmd && io_wdata[CB_WRITE] && armed && !busy;
  assign start_rd = wr_cmd && io_wdata[CB_READ] && !busy;
  assign abort    = busy && (wr_ptr || wr_data);

  nvm_arm_timer #(.ARM_CYCLES(ARM_CYCLES)) u_arm (
    .clk       (clk),
    .rst       (rst),
    .set_i     (wr_cmd && io_wdata[CB_ARM]),
    .consume_i (start_wr),
    .armed_o   (armed)
  );

  nvm_write_seq #(.WRITE_CYCLES(WRITE_CYCLES), .AW(ADDR_BITS), .DW(DW)) u_wseq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_wr),
    .abort_i    (abort),
    .addr_i     (ptr_q),
    .data_i     (data_q),
    .busy_o     (busy),
    .mem_we_o   (mem_we),
    .mem_addr_o (mem_waddr),
    .mem_data_o (mem_wdata)
  );

  nvm_array #(.AW(ADDR_BITS), .DW(DW)) u_mem (
    .clk     (clk),
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wdata   (mem_wdata),
    .re      (start_rd),
    .raddr   (ptr_q),
    .rdata_q (mem_rdata)
  );

  nvm_stall #(.RD_STALL(RD_STALL), .WR_STALL(WR_STALL)) u_stall (
    .clk        (clk),
    .rst        (rst),
    .load_rd_i  (start_rd),
    .load_wr_i  (start_wr),
    .stall_o    (cpu_stall),
    .rd_phase_o (rd_phase)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q     <= '0;
      data_q    <= '0;
      irqen_q   <= 1'b0;
      rd_load_q <= 1'b0;
    end else begin
      rd_load_q <= start_rd;
      if (wr_ptr)  ptr_q   <= io_wdata[ADDR_BITS-1:0];
      if (wr_cmd)  irqen_q <= io_wdata[CB_IRQEN];
      if (wr_data)        data_q <= io_wdata;
      else if (rd_load_q) data_q <= mem_rdata;
    end
  end

  always_comb begin
    cmd_view            = '0;
    cmd_view[CB_IRQEN]  = irqen_q;
    cmd_view[CB_ARM]    = armed;
    cmd_view[CB_WRITE]  = busy;
    cmd_view[CB_READ]   = rd_phase;
    ptr_view            = '0;
    ptr_view[ADDR_BITS-1:0] = ptr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) io_rdata <= '0;
    else begin
      unique case (sel)
        SEL_PTR:  io_rdata <= ptr_view;
        SEL_DATA: io_rdata <= data_q;
        SEL_CMD:  io_rdata <= cmd_view;
        default:  io_rdata <= '0;
      endcase
    end
  end

  assign irq = irqen_q && gie && !busy;

  // R4: a write can only begin from an armed state
  p_start_needs_arm_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(armed));
  // R8: write start is accompanied by a stall
  p_wr_stall_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> cpu_stall);
  // R7: the read bit is only visible inside a stall window
  p_rd_stall_r7: assert property (@(posedge clk) disable iff (rst)
    rd_phase |-> cpu_stall);
  // R9: interrupt never asserts while busy
  p_irq_idle_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> (!busy && gie));
  // R10: a register write during busy ends the write next cycle
  p_abort_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && (wr_ptr || wr_data)) |=> !busy);
  // R2: upper pointer bits read as zero
  p_ptr_hi_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(io_sel) == 2'd0) |-> (io_rdata[7:6] == 2'b00));
  // R3: upper command bits read as zero
  p_cmd_hi_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(io_sel) == 2'd2) |-> (io_rdata[7:4] == 4'h0));
  // R11: a read during busy starts no stall
  p_rd_busy_r11: assert property (@(posedge clk) disable iff (rst)
    (busy && !cpu_stall && wr_cmd && io_wdata[0]) |=> !cpu_stall);
endmodule

// File: tb/tb_nvm_regblock.sv
module tb_nvm_regblock;
  localparam int WCYC = 24;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] io_sel;
  logic       io_we;
  logic [7:0] io_wdata;
  logic [7:0] io_rdata;
  logic       gie;
  logic       irq;
  logic       cpu_stall;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [7:0] model [64];
  logic       irqen = 1'b0;

  always #5 clk = ~clk;

  nvm_regblock #(.WRITE_CYCLES(WCYC)) dut (
    .clk(clk), .rst(rst), .io_sel(io_sel), .io_we(io_we),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .gie(gie),
    .irq(irq), .cpu_stall(cpu_stall)
  );

  function automatic logic [7:0] exp_cmd(logic ie, logic arm, logic bsy, logic rd);
    return {4'h0, ie, arm, bsy, rd};
  endfunction

  function automatic logic exp_irq(logic ie, logic g, logic bsy);
    return ie & g & ~bsy;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] s, logic [7:0] d);
    io_sel = s; io_wdata = d; io_we = 1'b1;
    @(posedge clk); @(negedge clk);
    io_we = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] s, output logic [7:0] d);
    io_sel = s; io_we = 1'b0;
    @(posedge clk); @(negedge clk);
    d = io_rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    logic [7:0] c;
    for (int i = 0; i < 4 * WCYC; i++) begin
      bus_read(2'd2, c);
      if (c[1] == 1'b0) break;
    end
  endtask

  task automatic count_stall(output int n);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      if (!cpu_stall) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_write(logic [5:0] a, logic [7:0] d);
    bus_write(2'd0, {2'b00, a});
    bus_write(2'd1, d);
    bus_write(2'd2, {4'h0, irqen, 3'b100});
    bus_write(2'd2, {4'h0, irqen, 3'b010});
    wait_idle();
    model[a] = d;
  endtask

  task automatic do_read(logic [5:0] a, output logic [7:0] d);
    bus_write(2'd0, {2'b00, a});
    bus_write(2'd2, {4'h0, irqen, 3'b001});
    idle(5);
    bus_read(2'd1, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int n;
    void'($urandom(32'h1234_5678));
    rst = 1'b1; io_sel = 2'd0; io_we = 1'b0; io_wdata = 8'h00; gie = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 stall", cpu_stall, 0);
    bus_read(2'd2, r); check("R1 cmd", r, 8'h00);
    bus_read(2'd1, r); check("R1 data", r, 8'h00);

    // R2 register map
    bus_write(2'd0, 8'hFF); bus_read(2'd0, r); check("R2 ptr hi bits", r, 8'h3F);
    bus_write(2'd1, 8'hA5); bus_read(2'd1, r); check("R2 data readback", r, 8'hA5);
    bus_read(2'd3, r); check("R2 unused sel", r, 8'h00);

    // R3 command layout: all-ones with no arm gives only irq enable
    bus_write(2'd2, 8'hF8); bus_read(2'd2, r);
    check("R3 cmd fields", r, exp_cmd(1, 0, 0, 0));
    bus_write(2'd2, 8'h00); bus_read(2'd2, r);
    check("R3 irqen clear", r, 8'h00);

    // preload store
    for (int i = 0; i < 64; i++) do_write(6'(i), 8'((i * 37 + 11) & 8'hFE));

    // R4 write without arm
    bus_write(2'd0, 8'd7); bus_write(2'd1, 8'h5A);
    bus_write(2'd2, 8'h02);
    bus_read(2'd2, r); check("R4 no busy", r[1], 0);
    do_read(6'd7, r); check("R4 store unchanged", r, model[7]);

    // R5 arm visibility and lapse
    bus_write(2'd2, 8'h04);
    bus_read(2'd2, r); check("R5 arm set", r[2], 1);
    idle(2);
    bus_read(2'd2, r); check("R5 arm 4th cycle", r[2], 1);
    bus_read(2'd2, r); check("R5 arm lapsed", r[2], 0);

    // R5 window edges
    for (int k = 0; k <= 4; k++) begin
      bus_write(2'd0, 8'(20 + k)); bus_write(2'd1, 8'(8'h60 + k));
      bus_write(2'd2, 8'h04);
      idle(k);
      bus_write(2'd2, 8'h02);
      bus_read(2'd2, r);
      check($sformatf("R5 window k=%0d", k), r[1], (k <= 3) ? 1 : 0);
      if (k <= 3) begin
        check("R5 arm consumed", r[2], 0);
        model[20 + k] = 8'(8'h60 + k);
      end
      wait_idle(); idle(6);
      do_read(6'(20 + k), r); check("R5 store", r, model[20 + k]);
    end

    // R6 busy length via irq and latched operands; R8 write stall
    gie = 1'b1; irqen = 1'b1;
    bus_write(2'd2, 8'h08);
    check("R9 idle irq", irq, exp_irq(1, 1, 0));
    bus_write(2'd0, 8'd40); bus_write(2'd1, 8'hC3);
    bus_write(2'd2, 8'h0C); bus_write(2'd2, 8'h0A);
    check("R9 busy irq", irq, exp_irq(1, 1, 1));
    count_stall(n); check("R8 write stall", n, 2);
    n = n + 1;
    // irq was already low the start cycle; count remaining
    for (int i = 0; i < 4 * WCYC; i++) begin
      if (irq) break;
      n++;
      @(negedge clk);
    end
    check("R6 busy cycles", n - 1, WCYC);
    model[40] = 8'hC3;
    do_read(6'd40, r); check("R6 stored", r, 8'hC3);
    gie = 1'b0; @(negedge clk);
    check("R9 gie off", irq, 0);
    gie = 1'b1; bus_write(2'd2, 8'h00); irqen = 1'b0;
    check("R9 ie off", irq, 0);

    // R7 read timing
    bus_write(2'd0, 8'd3);
    bus_write(2'd2, 8'h01);
    check("R7 stall start", cpu_stall, 1);
    bus_read(2'd2, r); check("R7 read bit", r[0], 1);
    count_stall(n); check("R7 stall len", n + 1, 4);
    bus_read(2'd2, r); check("R7 read bit clear", r[0], 0);
    bus_read(2'd1, r); check("R7 data", r, model[3]);

    // R11 read during busy; R10 abort via pointer
    bus_write(2'd0, 8'd5); bus_write(2'd1, 8'h3C);
    bus_write(2'd2, 8'h04); bus_write(2'd2, 8'h02);
    idle(3);
    bus_write(2'd2, 8'h01);
    check("R11 no stall", cpu_stall, 0);
    idle(4);
    bus_read(2'd1, r); check("R11 data kept", r, 8'h3C);
    bus_write(2'd0, 8'd9);
    bus_read(2'd2, r); check("R10 busy cleared", r[1], 0);
    model[5] = 8'hFF;
    do_read(6'd5, r); check("R10 poison ptr", r, 8'hFF);
    do_read(6'd9, r); check("R10 other intact", r, model[9]);

    // R10 abort via data
    bus_write(2'd0, 8'd12); bus_write(2'd1, 8'h11);
    bus_write(2'd2, 8'h04); bus_write(2'd2, 8'h02);
    idle(7);
    bus_write(2'd1, 8'h22);
    bus_read(2'd1, r); check("R10 data taken", r, 8'h22);
    model[12] = 8'hFF;
    do_read(6'd12, r); check("R10 poison data", r, 8'hFF);

    // random phase
    for (int t = 0; t < 300; t++) begin
      int op = int'($urandom_range(0, 7));
      logic [5:0] a = 6'($urandom_range(0, 63));
      logic [7:0] d = 8'($urandom_range(0, 255));
      if (op < 3) do_write(a, d);
      else if (op < 6) begin
        do_read(a, r); check("R7 random read", r, model[a]);
      end else begin
        bus_write(2'd0, {2'b00, a}); bus_write(2'd1, d);
        bus_write(2'd2, 8'h04); bus_write(2'd2, 8'h02);
        idle(int'($urandom_range(1, WCYC - 6)));
        bus_write(2'd1, ~d);
        model[a] = 8'hFF;
        do_read(a, r); check("R10 random abort", r, 8'hFF);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule